// File: doc/BRIEF.md
# Interrupt Cause Register Bank

The block collects up to 32 interrupt sources into one word-wide cause register, gates it with a mask, and drives one interrupt line that is high while any unmasked cause is pending. Hardware sources arrive as single-cycle pulses and are held in a cause latch until software clears them. Software can also raise a cause itself, which is useful for testing and for signalling between processors.

Each cause bit has its own clearing style, chosen by a bit in a control register. With the control bit at 0 the cause bit is cleared by writing a 1 to it. With the control bit at 1 it is cleared when it is read. The raw cause view and the masked cause view both follow that per-bit style. The mask can be written as a whole word, or changed bit by bit through separate set and clear strobe registers.

Software reaches the bank through a simple word-addressed read/write port. Read data is registered and returns the cycle after the request.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset all cause bits are 0, all mask bits are 1, every control bit is 0, and `irq_o` is low.
- R2: A one-cycle pulse on bit i of `evt_i` sets cause bit i. The new value is visible from the following cycle.
- R3: A write to offset 3 sets every cause bit whose data bit is 1. Offsets 3, 5, 6 and the unused offset 7 read as zero.
- R4: A cause bit whose control bit (offset 0) is 0 is cleared by a write with that data bit at 1 to offset 1 or 2. A write with the data bit at 0, or a read, leaves it unchanged.
- R5: A cause bit whose control bit is 1 is cleared by any read of offset 1 or 2. Writes to those offsets leave it unchanged.
- R6: A read of offset 2 returns cause AND NOT mask. Reads and writes to offset 2 clear the underlying raw cause bit under the same per-bit rules as offset 1, whether or not that bit is masked.
- R7: Offset 4 is the mask, which can be read and written. A write to offset 5 sets the mask bits whose data bits are 1. A write to offset 6 clears them. Other mask bits keep their values. A mask bit of 1 blocks its source.
- R8: `irq_o` is high exactly when some bit of cause AND NOT mask is 1. It follows the register state with no added cycle.
- R9: When a set (from an event or a write to offset 3) and a clear hit the same cause bit in the same cycle, the bit ends up at 1.
- R10: Read data appears on `rdata_o` in the cycle after `rd_en_i`. It holds the register value from before that read's own clearing takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_SRC | Hardware event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word offset of the register |
| wdata_i | input | N_SRC | Write data |
| rdata_o | output | N_SRC | Registered read data |
| irq_o | output | 1 | Interrupt request: OR of the unmasked causes |

## Verification
The bench runs both clearing styles side by side in one word. This exposes a design that applies one style to every bit, for example by clearing a write-one-to-clear bit on a read or by ignoring a clear-on-read bit. It clears through the masked view while the bit is still masked, which catches a design that gates the clear with the mask. It also checks that reads return the value from before their own clearing, since a design that returned the post-clear value would lose events. It lands an event on the same cycle as a write-one clear and as a clearing read, where a design that let the clear win would drop that interrupt. It checks that the write-only offsets read back as zero and that `irq_o` tracks each change to the mask, which catches a stale or inverted mask path.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    OFS_CTRL   = 3'd0,
    OFS_CAUSE  = 3'd1,
    OFS_MASKED = 3'd2,
    OFS_SET    = 3'd3,
    OFS_MASK   = 3'd4,
    OFS_MSET   = 3'd5,
    OFS_MCLR   = 3'd6
  } reg_ofs_e;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_cause;  // write to raw or masked view
    logic rd_cause;  // read of raw or masked view
    logic wr_set;
    logic wr_mask;
    logic wr_mset;
    logic wr_mclr;
  } bank_stb_t;
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
(
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  output bank_stb_t             stb_o
);
  logic is_cause_view;

  always_comb begin
    is_cause_view  = (addr_i == OFS_CAUSE) || (addr_i == OFS_MASKED);
    stb_o          = '0;
    stb_o.wr_ctrl  = wr_en_i && (addr_i == OFS_CTRL);
    stb_o.wr_cause = wr_en_i && is_cause_view;
    stb_o.rd_cause = rd_en_i && is_cause_view;
    stb_o.wr_set   = wr_en_i && (addr_i == OFS_SET);
    stb_o.wr_mask  = wr_en_i && (addr_i == OFS_MASK);
    stb_o.wr_mset  = wr_en_i && (addr_i == OFS_MSET);
    stb_o.wr_mclr  = wr_en_i && (addr_i == OFS_MCLR);
  end
endmodule

// File: rtl/irq_cause_cell.sv
module irq_cause_cell
  import irq_bank_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      evt_i,
  input  logic      wdata_i,
  input  bank_stb_t stb_i,
  output logic      cause_o,
  output logic      mask_o,
  output logic      ctrl_o
);
  logic cause_q, mask_q, ctrl_q;
  logic set_hit, clr_hit;

  always_comb begin
    set_hit = evt_i || (stb_i.wr_set && wdata_i);
    clr_hit = ctrl_q ? stb_i.rd_cause : (stb_i.wr_cause && wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= 1'b0;
      mask_q  <= 1'b1;
      ctrl_q  <= 1'b0;
    end else begin
      if (set_hit)      cause_q <= 1'b1;  // set beats clear
      else if (clr_hit) cause_q <= 1'b0;
      if (stb_i.wr_ctrl) ctrl_q <= wdata_i;
      if (stb_i.wr_mask)                mask_q <= wdata_i;
      else if (stb_i.wr_mset && wdata_i) mask_q <= 1'b1;
      else if (stb_i.wr_mclr && wdata_i) mask_q <= 1'b0;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign ctrl_o  = ctrl_q;

  p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> cause_q);
  p_w1c_read_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q && stb_i.rd_cause && !stb_i.wr_cause && !evt_i && !stb_i.wr_set)
      |=> cause_q == $past(cause_q));
  p_cor_write_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q && stb_i.wr_cause && !stb_i.rd_cause && !evt_i && !stb_i.wr_set)
      |=> cause_q == $past(cause_q));
  p_mask_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i.wr_mset && wdata_i) |=> mask_q);
  p_mask_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i.wr_mclr && wdata_i) |=> !mask_q);
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && (stb_i.wr_cause || stb_i.rd_cause)) |=> cause_q);
endmodule

// File: rtl/irq_bank_rdmux.sv
module irq_bank_rdmux
  import irq_bank_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]      ctrl_i,
  input  logic [N_SRC-1:0]      cause_i,
  input  logic [N_SRC-1:0]      mask_i,
  output logic [N_SRC-1:0]      rdata_o
);
  logic [N_SRC-1:0] sel_d, rdata_q;

  always_comb begin
    unique case (addr_i)
      OFS_CTRL:   sel_d = ctrl_i;
      OFS_CAUSE:  sel_d = cause_i;
      OFS_MASKED: sel_d = cause_i & ~mask_i;
      OFS_MASK:   sel_d = mask_i;
      default:    sel_d = '0;  // write-only and unused offsets
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= sel_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_bank_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC-1:0]      evt_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]      wdata_i,
  output logic [N_SRC-1:0]      rdata_o,
  output logic                  irq_o
);
  bank_stb_t        stb;
  logic [N_SRC-1:0] cause_vec, mask_vec, ctrl_vec;

  irq_bank_decode u_dec (
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .stb_o   (stb)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_cell
    irq_cause_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i[i]),
      .wdata_i (wdata_i[i]),
      .stb_i   (stb),
      .cause_o (cause_vec[i]),
      .mask_o  (mask_vec[i]),
      .ctrl_o  (ctrl_vec[i])
    );
  end

  irq_bank_rdmux #(.N_SRC(N_SRC)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .ctrl_i  (ctrl_vec),
    .cause_i (cause_vec),
    .mask_i  (mask_vec),
    .rdata_o (rdata_o)
  );

  assign irq_o = |(cause_vec & ~mask_vec);

  p_wo_read_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == OFS_SET || addr_i == OFS_MSET ||
                 addr_i == OFS_MCLR || addr_i == 3'd7)) |=> rdata_o == '0);
  p_read_prior_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_CAUSE) |=> rdata_o == $past(cause_vec));
  p_all_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_vec) |-> !irq_o);
endmodule

// File: tb/tb_irq_cause_bank.sv
`timescale 1ns/1ps
module tb_irq_cause_bank;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq;

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] m_cause = '0, m_mask = '1, m_ctrl = '0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic         mon_vld = 1'b0;

  always #2 clk = ~clk;

  irq_cause_bank #(.N_SRC(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: a read issued before a rising edge is compared at the next falling edge
  always @(posedge clk) mon_vld <= rd_en;
  always @(negedge clk) begin
    if (mon_vld && exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  function automatic logic [N-1:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return m_cause;
      3'd2: return m_cause & ~m_mask;
      3'd4: return m_mask;
      default: return '0;
    endcase
  endfunction

  task automatic check_irq(input string t);
    logic e;
    e = |(m_cause & ~m_mask);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  // driver: one bus cycle, model updated per the requirements
  task automatic op(input bit w, input bit r, input logic [2:0] a,
                    input logic [N-1:0] d, input logic [N-1:0] ev, input string t);
    logic [N-1:0] clr, st;
    if (r) begin
      exp_q.push_back(model_read(a));
      tag_q.push_back(t);
    end
    wr_en = w; rd_en = r; addr = a; wdata = d; evt = ev;
    clr = '0;
    if (w && (a == 3'd1 || a == 3'd2)) clr |= d & ~m_ctrl;
    if (r && (a == 3'd1 || a == 3'd2)) clr |= m_ctrl;
    st = ev | ((w && a == 3'd3) ? d : '0);
    m_cause = (m_cause & ~clr) | st;
    if (w && a == 3'd0) m_ctrl = d;
    if (w && a == 3'd4) m_mask = d;
    if (w && a == 3'd5) m_mask |= d;
    if (w && a == 3'd6) m_mask &= ~d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; evt = '0;
    check_irq("R8");
  endtask

  task automatic rd(input logic [2:0] a, input string t); op(0, 1, a, '0, '0, t); endtask
  task automatic wr(input logic [2:0] a, input logic [N-1:0] d); op(1, 0, a, d, '0, "R8"); endtask
  task automatic pulse(input logic [N-1:0] ev); op(0, 0, 3'd0, '0, ev, "R2"); endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_irq("R1");
    rd(3'd0, "R1"); rd(3'd1, "R1"); rd(3'd2, "R1"); rd(3'd4, "R1");
    // R2 event capture, still masked
    pulse(32'h0000_0008);
    rd(3'd1, "R2");
    // R7 mask clear opens the source
    wr(3'd6, 32'h0000_0008);
    rd(3'd4, "R7");
    rd(3'd2, "R6");
    // R4 write-one-to-clear
    rd(3'd1, "R4");
    rd(3'd1, "R4");
    wr(3'd1, 32'h0000_0000);
    rd(3'd1, "R4");
    wr(3'd1, 32'h0000_0008);
    rd(3'd1, "R4");
    // R3 software set and write-only reads
    wr(3'd3, 32'h0000_0030);
    rd(3'd1, "R3");
    rd(3'd3, "R3"); rd(3'd5, "R3"); rd(3'd6, "R3"); rd(3'd7, "R3");
    // R5 clear-on-read on bit 4 alongside W1C on bit 5
    wr(3'd0, 32'h0000_0010);
    rd(3'd0, "R5");
    wr(3'd1, 32'h0000_0030);
    rd(3'd1, "R5");
    rd(3'd1, "R10");
    // R6 clearing through the masked view
    pulse(32'h0000_0010);
    wr(3'd6, 32'h0000_0010);
    rd(3'd2, "R6");
    rd(3'd1, "R6");
    wr(3'd3, 32'h0000_0020);
    rd(3'd2, "R6");
    wr(3'd2, 32'h0000_0020);
    rd(3'd1, "R6");
    // R7 whole-word mask write and mask-set
    wr(3'd4, 32'h0000_0000);
    rd(3'd4, "R7");
    wr(3'd5, 32'h0000_00F0);
    rd(3'd4, "R7");
    wr(3'd6, 32'hFFFF_FFFF);
    // R9 set wins over W1C write and over clearing read
    wr(3'd3, 32'h0000_0001);
    op(1, 0, 3'd1, 32'h0000_0001, 32'h0000_0001, "R9");
    rd(3'd1, "R9");
    wr(3'd3, 32'h0000_0010);
    op(0, 1, 3'd1, '0, 32'h0000_0010, "R9");
    rd(3'd1, "R9");
    rd(3'd1, "R10");
    // R8 mask all off again
    wr(3'd4, 32'hFFFF_FFFF);
    pulse(32'h8000_0000);
    wr(3'd6, 32'h8000_0000);
    rd(3'd2, "R8");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule